// File: doc/BRIEF.md
# TDM Frame Multiplexer

This block merges 24 byte-wide channel inputs onto a single time-division multiplexed output. A free-running slot counter steps through the 24 positions of a frame and drives the selection, so no outside control is needed. Each channel owns one fixed position, and that position comes back in every frame. A one-clock strobe marks the first slot of each frame.

All channel bytes are copied into a frame snapshot at a frame boundary, so the inputs may change at any time. Two interleaving modes are offered, and the mode input is taken only at frame boundaries. In byte mode, every slot presents the whole byte of its channel for one clock. In bit mode, every slot sends a single bit of its channel on the serial output. The first frame after a snapshot sends the most significant bit, and each following frame sends the next lower bit. A new snapshot is taken only after all bits have been sent.

Top module: `tdm_frame_mux`

## Requirements
- R1: `slot_o` starts at 0 after reset, rises by one every clock, and wraps from 23 to 0.
- R2: `frame_start_o` is high exactly in the cycles where `slot_o` is 0.
- R3: In byte mode, during slot s, `byte_o` equals the snapshot byte of channel s, `byte_vld_o` is 1 and `ser_vld_o` is 0. Channel c occupies `chan_data_i[8*c+7:8*c]`, and bit 7 is the most significant bit.
- R4: The snapshot is loaded on the clock edge that ends slot 23. Input changes during a frame do not alter that frame's output.
- R5: In bit mode, in the k-th frame after a snapshot (k = 0..7), slot s carries bit 7-k of channel s's snapshot byte on `ser_o`, with `ser_vld_o` at 1 and `byte_vld_o` at 0.
- R6: In bit mode, a new snapshot is taken only at the end of the eighth frame. Input changes during those eight frames are ignored.
- R7: `word_mode_i` (1 = byte mode, 0 = bit mode) is sampled only at the edge that ends slot 23. A mode change forces a new snapshot, and the bit index restarts at 7.
- R8: Until the first snapshot after reset, both valid flags are 0. Whenever a valid flag is 0, its data output is 0.
- R9: The asynchronous reset `rst_ni` at once sets the slot to 0, clears the snapshot and clears both valid flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_mode_i | input | 1 | 1 = byte per slot, 0 = bit per slot |
| chan_data_i | input | 192 | 24 channel bytes, channel c in bits 8c+7..8c |
| ser_o | output | 1 | Serial bit for the current slot |
| ser_vld_o | output | 1 | Serial output carries data |
| byte_o | output | 8 | Byte for the current slot |
| byte_vld_o | output | 1 | Byte output carries data |
| slot_o | output | 5 | Current slot index |
| frame_start_o | output | 1 | High while the slot index is 0 |

## Verification
The bench changes the inputs in the middle of a byte frame and during the eight frames of a bit-mode pass. A design that reads the live inputs, or that takes a snapshot every frame in bit mode, would put those new values on the line too early. The bench flips the mode in the middle of a frame. A design that applies the mode at once would drop the byte valid flag before the frame ends, and one that skips the forced snapshot on a switch would resume at the wrong bit. The bench also checks the empty first frame after reset and an asynchronous reset taken mid-frame. A design would fail here if it raised a valid flag over a cleared snapshot or kept counting through the reset.

// File: rtl/tdm_frame_mux_pkg.sv
package tdm_frame_mux_pkg;
  localparam int unsigned DEF_NUM_CH = 24;
  localparam int unsigned DEF_CH_W   = 8;

  typedef enum logic {
    MODE_BIT  = 1'b0,
    MODE_WORD = 1'b1
  } tdm_mode_e;
endpackage

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr #(
  parameter int unsigned NUM_CH = 24,
  localparam int unsigned SLOT_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o,
  output logic              frame_start_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CH - 1);

  logic [SLOT_W-1:0] slot_q;
  logic              fs_q;

  assign last_o = (slot_q == LAST_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      fs_q   <= 1'b1;
    end else if (last_o) begin
      slot_q <= '0;
      fs_q   <= 1'b1;
    end else begin
      slot_q <= slot_q + 1'b1;
      fs_q   <= 1'b0;
    end
  end

  assign slot_o        = slot_q;
  assign frame_start_o = fs_q;
endmodule

// File: rtl/tdm_phase_ctl.sv
module tdm_phase_ctl
  import tdm_frame_mux_pkg::*;
#(
  parameter int unsigned CH_W = 8,
  localparam int unsigned BIT_W = $clog2(CH_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_end_i,
  input  logic             word_mode_i,
  output logic             capture_o,
  output tdm_mode_e        mode_o,
  output logic [BIT_W-1:0] bit_sel_o,
  output logic             primed_o
);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(CH_W - 1);

  tdm_mode_e        mode_q;
  logic [BIT_W-1:0] bit_sel_q;
  logic             primed_q;
  logic             need_load;

  // load on first frame, any byte-mode boundary, mode exit, or bits exhausted
  assign need_load = !primed_q || word_mode_i || (mode_q == MODE_WORD) ||
                     (bit_sel_q == '0);
  assign capture_o = frame_end_i && need_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_BIT;
      bit_sel_q <= TOP_BIT;
      primed_q  <= 1'b0;
    end else if (frame_end_i) begin
      mode_q <= word_mode_i ? MODE_WORD : MODE_BIT;
      if (need_load) begin
        primed_q  <= 1'b1;
        bit_sel_q <= TOP_BIT;
      end else begin
        bit_sel_q <= bit_sel_q - 1'b1;
      end
    end
  end

  assign mode_o    = mode_q;
  assign bit_sel_o = bit_sel_q;
  assign primed_o  = primed_q;
endmodule

// File: rtl/tdm_chan_store.sv
module tdm_chan_store #(
  parameter int unsigned NUM_CH = 24,
  parameter int unsigned CH_W   = 8,
  localparam int unsigned TOT_W = NUM_CH * CH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [TOT_W-1:0] data_i,
  output logic [TOT_W-1:0] hold_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CH_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        byte_q <= '0;
      else if (capture_i) byte_q <= data_i[c*CH_W +: CH_W];
    end
    assign hold_o[c*CH_W +: CH_W] = byte_q;
  end
endmodule

// File: rtl/tdm_out_sel.sv
module tdm_out_sel
  import tdm_frame_mux_pkg::*;
#(
  parameter int unsigned NUM_CH = 24,
  parameter int unsigned CH_W   = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_CH),
  localparam int unsigned BIT_W  = $clog2(CH_W),
  localparam int unsigned TOT_W  = NUM_CH * CH_W
) (
  input  logic [TOT_W-1:0]  hold_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BIT_W-1:0]  bit_sel_i,
  input  tdm_mode_e         mode_i,
  input  logic              primed_i,
  output logic              ser_o,
  output logic              ser_vld_o,
  output logic [CH_W-1:0]   byte_o,
  output logic              byte_vld_o
);
  logic [CH_W-1:0] cur;

  always_comb begin
    cur = '0;
    for (int c = 0; c < int'(NUM_CH); c++) begin
      if (slot_i == SLOT_W'(c)) cur = hold_i[c*CH_W +: CH_W];
    end
  end

  assign ser_vld_o  = primed_i && (mode_i == MODE_BIT);
  assign byte_vld_o = primed_i && (mode_i == MODE_WORD);
  assign ser_o      = ser_vld_o ? cur[bit_sel_i] : 1'b0;
  assign byte_o     = byte_vld_o ? cur : '0;
endmodule

// File: rtl/tdm_frame_mux.sv
module tdm_frame_mux
  import tdm_frame_mux_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned CH_W   = DEF_CH_W,
  localparam int unsigned SLOT_W = $clog2(NUM_CH),
  localparam int unsigned BIT_W  = $clog2(CH_W),
  localparam int unsigned TOT_W  = NUM_CH * CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_mode_i,
  input  logic [TOT_W-1:0]  chan_data_i,
  output logic              ser_o,
  output logic              ser_vld_o,
  output logic [CH_W-1:0]   byte_o,
  output logic              byte_vld_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_start_o
);
  logic              frame_end;
  logic              capture;
  tdm_mode_e         mode;
  logic [BIT_W-1:0]  bit_sel;
  logic              primed;
  logic [TOT_W-1:0]  hold;

  tdm_slot_ctr #(.NUM_CH(NUM_CH)) u_ctr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .slot_o        (slot_o),
    .last_o        (frame_end),
    .frame_start_o (frame_start_o)
  );

  tdm_phase_ctl #(.CH_W(CH_W)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_end_i (frame_end),
    .word_mode_i (word_mode_i),
    .capture_o   (capture),
    .mode_o      (mode),
    .bit_sel_o   (bit_sel),
    .primed_o    (primed)
  );

  tdm_chan_store #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .data_i    (chan_data_i),
    .hold_o    (hold)
  );

  tdm_out_sel #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_out (
    .hold_i     (hold),
    .slot_i     (slot_o),
    .bit_sel_i  (bit_sel),
    .mode_i     (mode),
    .primed_i   (primed),
    .ser_o      (ser_o),
    .ser_vld_o  (ser_vld_o),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o)
  );
endmodule

// File: rtl/tdm_frame_mux_chk.sv
module tdm_frame_mux_chk #(
  parameter int unsigned NUM_CH = 24,
  parameter int unsigned CH_W   = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ser_o,
  input logic              ser_vld_o,
  input logic [CH_W-1:0]   byte_o,
  input logic              byte_vld_o,
  input logic [SLOT_W-1:0] slot_o,
  input logic              frame_start_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CH - 1);

  // R1
  slot_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o == LAST_SLOT) |=> (slot_o == '0));

  // R1
  slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o != LAST_SLOT) |=> (slot_o == SLOT_W'($past(slot_o) + 1'b1)));

  // R2
  frame_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o == (slot_o == '0));

  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_o |-> ($stable(byte_vld_o) && $stable(ser_vld_o)));

  // R3
  vld_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ser_vld_o, byte_vld_o}));

  // R8
  byte_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_o |-> (byte_o == '0));

  // R8
  ser_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_vld_o |-> !ser_o);
endmodule

bind tdm_frame_mux tdm_frame_mux_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ser_o         (ser_o),
  .ser_vld_o     (ser_vld_o),
  .byte_o        (byte_o),
  .byte_vld_o    (byte_vld_o),
  .slot_o        (slot_o),
  .frame_start_o (frame_start_o)
);

// File: tb/tdm_frame_mux_tb_top.sv
module tdm_frame_mux_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         word_mode_i = 1'b0;
  logic [191:0] chan_data_i = '0;
  logic         ser_o, ser_vld_o, byte_vld_o, frame_start_o;
  logic [7:0]   byte_o;
  logic [4:0]   slot_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tdm_frame_mux dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .word_mode_i   (word_mode_i),
    .chan_data_i   (chan_data_i),
    .ser_o         (ser_o),
    .ser_vld_o     (ser_vld_o),
    .byte_o        (byte_o),
    .byte_vld_o    (byte_vld_o),
    .slot_o        (slot_o),
    .frame_start_o (frame_start_o)
  );

  function automatic logic [7:0] pat(int seed, int c);
    return 8'(((c * 29) + (seed * 7)) ^ (c << 2) ^ seed);
  endfunction

  function automatic logic [191:0] frame_pat(int seed);
    logic [191:0] v;
    for (int c = 0; c < 24; c++) v[c*8 +: 8] = pat(seed, c);
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sync_to(int n);
    do @(negedge clk_i); while (int'(slot_o) != n);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk(slot_o == 0, "R9 slot", slot_o, 0);
    chk(frame_start_o, "R2 strobe at reset", frame_start_o, 1);
    chk(!ser_vld_o && !byte_vld_o, "R9 valids", {ser_vld_o, byte_vld_o}, 0);
    chk(byte_o == 0 && !ser_o, "R9 data", {byte_o, ser_o}, 0);
  endtask

  task automatic t_slot_seq;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk_i);
      chk(int'(slot_o) == i % 24, "R1 slot step", slot_o, i % 24);
      chk(frame_start_o == (i % 24 == 0), "R2 strobe", frame_start_o, (i % 24 == 0));
      chk(ser_vld_o == (i >= 24), "R8 first frame empty", ser_vld_o, (i >= 24));
      chk(!byte_vld_o && byte_o == 0, "R8 byte idle", {byte_vld_o, byte_o}, 0);
    end
  endtask

  task automatic t_word;
    logic [191:0] a = frame_pat(3);
    logic [191:0] b = frame_pat(11);
    sync_to(23);
    word_mode_i = 1'b1;
    chan_data_i = a;
    for (int s = 0; s < 24; s++) begin
      @(negedge clk_i);
      chk(byte_o == a[s*8 +: 8], "R3 byte out", byte_o, a[s*8 +: 8]);
      chk(byte_vld_o && !ser_vld_o && !ser_o, "R3 valids", {byte_vld_o, ser_vld_o, ser_o}, 3'b100);
      if (s == 5) chan_data_i = b;
    end
    for (int s = 0; s < 24; s++) begin
      @(negedge clk_i);
      chk(byte_o == b[s*8 +: 8], "R4 next frame snapshot", byte_o, b[s*8 +: 8]);
    end
  endtask

  task automatic t_bit;
    logic [191:0] c = frame_pat(21);
    logic [191:0] d = frame_pat(40);
    word_mode_i = 1'b0;
    chan_data_i = c;
    for (int f = 0; f < 8; f++) begin
      for (int s = 0; s < 24; s++) begin
        @(negedge clk_i);
        chk(ser_o == c[s*8 + 7 - f], "R5 serial bit", ser_o, c[s*8 + 7 - f]);
        chk(ser_vld_o && !byte_vld_o && byte_o == 0, "R5 valids", {ser_vld_o, byte_vld_o, byte_o}, 10'h200);
        if (f == 0 && s == 3) chan_data_i = d;
      end
    end
    for (int s = 0; s < 24; s++) begin
      @(negedge clk_i);
      chk(ser_o == d[s*8 + 7], "R6 reload after eight frames", ser_o, d[s*8 + 7]);
    end
  endtask

  task automatic t_switch;
    logic [191:0] e = frame_pat(57);
    word_mode_i = 1'b1;
    chan_data_i = e;
    for (int s = 0; s < 24; s++) begin
      @(negedge clk_i);
      chk(byte_vld_o && byte_o == e[s*8 +: 8], "R7 byte frame held", {byte_vld_o, byte_o}, {1'b1, e[s*8 +: 8]});
      if (s == 10) word_mode_i = 1'b0;
    end
    for (int s = 0; s < 24; s++) begin
      @(negedge clk_i);
      chk(ser_vld_o && ser_o == e[s*8 + 7], "R7 bit index restart", {ser_vld_o, ser_o}, {1'b1, e[s*8 + 7]});
    end
  endtask

  task automatic t_async;
    sync_to(9);
    rst_ni = 1'b0;
    #1;
    chk(slot_o == 0, "R9 async slot", slot_o, 0);
    chk(!ser_vld_o && !byte_vld_o && !ser_o && byte_o == 0, "R9 async outputs",
        {ser_vld_o, byte_vld_o, ser_o, byte_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk_i);
      chk(int'(slot_o) == i && !ser_vld_o && !byte_vld_o, "R8 empty after reset",
          {slot_o, ser_vld_o, byte_vld_o}, {5'(i), 2'b00});
    end
  endtask

  initial begin
    t_reset();
    t_slot_seq();
    t_word();
    t_bit();
    t_switch();
    t_async();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule